// File: doc/BRIEF.md
# Shared Counter Timer with Per-Core Compare Banks

This block keeps a single 64-bit up-counter that every processor core in a cluster sees, and gives each core a private comparator bank. A bank holds a 64-bit compare value, a 32-bit step value, three control bits and one sticky status bit. Each bank drives its own interrupt line. The counter advances at the input clock rate divided by a programmable factor. When the count reaches a core's compare value, that core's status bit is set. If the bank has auto-stepping enabled, the compare value moves forward by the step on its own, so one setup produces a steady periodic tick.

Software reaches the block through a simple 32-bit register port. A core-ID input chooses which bank the banked registers address. The run bit and the prescaler belong to all cores. The compare, interrupt and step bits belong to the addressed core. A read of control returns both kinds merged into one word. Reads are combinational and have no side effects. A write is applied on the clock edge where `req_i` and `we_i` are both high.

Top module: `shared_cmp_timer`

## Requirements
- R1: While run (control bit 0) is 1, the counter increases by exactly one every (P+1) clocks, where P is control bits 15:8. The increment carries across the full 64 bits. While run is 0 the counter holds its value.
- R2: Writes to word 0 (count bits 31:0) and word 1 (count bits 63:32) load only that half, and only while run is 0. While run is 1 these writes are ignored.
- R3: Run and P are shared by all cores. Compare enable (bit 1), interrupt enable (bit 2) and auto-step enable (bit 3) are stored per core. A control write (word 2) updates the shared fields and the addressed core's bank. A control read returns the shared fields merged with that core's bank bits.
- R4: One clock after an edge where run is 1, the core's compare enable is 1 and count >= compare value (unsigned 64-bit), that core's status bit (word 3, bit 0) is 1. Status is set only by such an event. A compare value at or below the current count therefore fires right away.
- R5: A core's interrupt output equals its status bit ANDed with its interrupt enable bit.
- R6: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R7: On an event with auto-step enabled and a nonzero step (word 6), the compare value grows by one step per clock until it exceeds the count. With the count held, it ends at the smallest compare + k*step that is above the count. A step of zero leaves the compare value unchanged.
- R8: Word 4 and word 5 each write only their own 32-bit half of the compare value (bits 31:0 and 63:32). A bus write to the compare value takes priority over an auto-step in the same cycle.
- R9: Word 7 reads 0. `rdata_o` is 0 whenever no read is requested.
- R10: Reset clears the counter, run, P, and every core's control bits, status, compare value and step. All interrupts are low after reset.
- R11: A bank access from one core leaves every other core's bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| core_i | input | CORE_W | Core ID; selects the bank the access reaches |
| addr_i | input | 3 | 32-bit word index inside the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the request |
| irq_o | output | NUM_CORES | One interrupt line per core |

## Verification
The bench counts prescaled ticks exactly. A design that ticked every P clocks instead of every P+1, or that leaked a tick at the edge that stops the counter, would show a count off by one. It writes the counter while it runs and clears status while a compare is still active. A design that let the write through, or that gave the clear priority over the event, would read back the wrong value. It starts auto-stepping with the count already several steps past the compare value and with a step of zero. Stopping too early, overshooting by an extra step, or wrapping on a zero step all show up in the final compare value. Finally, it carries the count across the 32-bit boundary and merges control reads from two cores. A lost carry or a banked bit leaking into another core's read gives a wrong word.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CNT_W     = 64;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STS    = 3'd3,
    REG_CMP_LO = 3'd4,
    REG_CMP_HI = 3'd5,
    REG_STEP   = 3'd6
  } reg_idx_e;

  localparam int unsigned CTRL_RUN     = 0;
  localparam int unsigned CTRL_CMP     = 1;
  localparam int unsigned CTRL_IE      = 2;
  localparam int unsigned CTRL_AUTO    = 3;
  localparam int unsigned CTRL_PSC_LSB = 8;

  typedef struct packed {
    logic auto_en;
    logic irq_en;
    logic cmp_en;
  } bank_ctrl_t;
endpackage

// File: rtl/sct_prescaler.sv
module sct_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q;

  // >= so a divider lowered mid-count does not wait for a wrap
  assign tick_o = run_i && (pcnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!run_i || tick_o)  pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned HI_W = CNT_W - WORD_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (tick_i) begin
      count_o <= count_o + 1'b1;
    end else if (!run_i) begin
      if (wr_lo_i) count_o[WORD_W-1:0]     <= wdata_i;
      if (wr_hi_i) count_o[CNT_W-1:WORD_W] <= wdata_i[HI_W-1:0];
    end
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> count_o == $past(count_o) + 1'b1);

  assert_count_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(count_o));
endmodule

// File: rtl/sct_bank.sv
module sct_bank import sct_pkg::*; #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned INC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ctrl_we_i,
  input  logic              sts_we_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic              step_we_i,
  output bank_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [INC_W-1:0]  step_o,
  output logic              status_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = CNT_W - WORD_W;

  logic hit;
  logic do_step;

  assign hit     = run_i && ctrl_o.cmp_en && (count_i >= cmp_o);
  assign do_step = hit && ctrl_o.auto_en && (step_o != '0);
  assign irq_o   = status_o && ctrl_o.irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      cmp_o    <= '0;
      step_o   <= '0;
      status_o <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_o.cmp_en  <= wdata_i[CTRL_CMP];
        ctrl_o.irq_en  <= wdata_i[CTRL_IE];
        ctrl_o.auto_en <= wdata_i[CTRL_AUTO];
      end
      if (step_we_i) step_o <= wdata_i[INC_W-1:0];
      // bus write beats auto-step
      if (cmp_lo_we_i || cmp_hi_we_i) begin
        if (cmp_lo_we_i) cmp_o[WORD_W-1:0]     <= wdata_i;
        if (cmp_hi_we_i) cmp_o[CNT_W-1:WORD_W] <= wdata_i[HI_W-1:0];
      end else if (do_step) begin
        cmp_o <= cmp_o + CNT_W'(step_o);
      end
      // event beats write-one-to-clear
      if (hit)                          status_o <= 1'b1;
      else if (sts_we_i && wdata_i[0])  status_o <= 1'b0;
    end
  end

  assert_event_sets_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ctrl_o.cmp_en && count_i >= cmp_o) |=> status_o);

  assert_status_origin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(run_i && ctrl_o.cmp_en));

  assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !(sts_we_i && wdata_i[0])) |=> status_o);

  assert_auto_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_step && !cmp_lo_we_i && !cmp_hi_we_i) |=> cmp_o == $past(cmp_o) + CNT_W'($past(step_o)));

  assert_zero_step_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == '0 && !cmp_lo_we_i && !cmp_hi_we_i) |=> $stable(cmp_o));
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer import sct_pkg::*; #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned PSC_W     = 8,
  parameter int unsigned INC_W     = 32,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [CORE_W-1:0]    core_i,
  input  logic [REG_IDX_W-1:0] addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  logic             wr;
  logic             run_q;
  logic [PSC_W-1:0] psc_q;
  logic             tick;
  logic [CNT_W-1:0] count;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      psc_q <= '0;
    end else if (wr && addr_i == REG_CTRL) begin
      run_q <= wdata_i[CTRL_RUN];
      psc_q <= wdata_i[CTRL_PSC_LSB +: PSC_W];
    end
  end

  sct_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .div_i  (psc_q),
    .tick_o (tick)
  );

  sct_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick),
    .wr_lo_i (wr && addr_i == REG_CNT_LO),
    .wr_hi_i (wr && addr_i == REG_CNT_HI),
    .wdata_i (wdata_i),
    .count_o (count)
  );

  bank_ctrl_t       b_ctrl [NUM_CORES];
  logic [CNT_W-1:0] b_cmp  [NUM_CORES];
  logic [INC_W-1:0] b_step [NUM_CORES];
  logic             b_sts  [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank
    logic sel;
    assign sel = wr && (core_i == CORE_W'(g));

    sct_bank #(.CNT_W(CNT_W), .WORD_W(WORD_W), .INC_W(INC_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_q),
      .count_i     (count),
      .wdata_i     (wdata_i),
      .ctrl_we_i   (sel && addr_i == REG_CTRL),
      .sts_we_i    (sel && addr_i == REG_STS),
      .cmp_lo_we_i (sel && addr_i == REG_CMP_LO),
      .cmp_hi_we_i (sel && addr_i == REG_CMP_HI),
      .step_we_i   (sel && addr_i == REG_STEP),
      .ctrl_o      (b_ctrl[g]),
      .cmp_o       (b_cmp[g]),
      .step_o      (b_step[g]),
      .status_o    (b_sts[g]),
      .irq_o       (irq_o[g])
    );
  end

  bank_ctrl_t       s_ctrl;
  logic [CNT_W-1:0] s_cmp;
  logic [INC_W-1:0] s_step;
  logic             s_sts;

  always_comb begin
    s_ctrl = '0;
    s_cmp  = '0;
    s_step = '0;
    s_sts  = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (core_i == CORE_W'(c)) begin
        s_ctrl = b_ctrl[c];
        s_cmp  = b_cmp[c];
        s_step = b_step[c];
        s_sts  = b_sts[c];
      end
    end
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        REG_CNT_LO: rdata_o = count[WORD_W-1:0];
        REG_CNT_HI: rdata_o = count[CNT_W-1:WORD_W];
        REG_CTRL: begin
          rdata_o[CTRL_RUN]               = run_q;
          rdata_o[CTRL_CMP]               = s_ctrl.cmp_en;
          rdata_o[CTRL_IE]                = s_ctrl.irq_en;
          rdata_o[CTRL_AUTO]              = s_ctrl.auto_en;
          rdata_o[CTRL_PSC_LSB +: PSC_W]  = psc_q;
        end
        REG_STS:    rdata_o[0] = s_sts;
        REG_CMP_LO: rdata_o = s_cmp[WORD_W-1:0];
        REG_CMP_HI: rdata_o = s_cmp[CNT_W-1:WORD_W];
        REG_STEP:   rdata_o[INC_W-1:0] = s_step;
        default:    rdata_o = '0;
      endcase
    end
  end

  assert_cnt_write_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && run_q && !tick && (addr_i == REG_CNT_LO || addr_i == REG_CNT_HI))
      |=> $stable(count));

  assert_idle_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> rdata_o == '0);
endmodule

// File: tb/sim_shared_cmp_timer.sv
`timescale 1ns/1ps
module sim_shared_cmp_timer;
  localparam int NC = 4;
  localparam int A_CLO = 0, A_CHI = 1, A_CTRL = 2, A_STS = 3;
  localparam int A_CMPLO = 4, A_CMPHI = 5, A_STEP = 6, A_NONE = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  core = '0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  shared_cmp_timer #(.NUM_CORES(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .core_i(core),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string rid, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rid, act, exp);
    end
  endtask

  task automatic wr(int c, int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; core = c[1:0]; addr = a[2:0]; wdata = d;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int c, int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; core = c[1:0]; addr = a[2:0];
    #1;
    d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_check(string rid, int c, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(c, a, d);
    check(rid, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_check("R10", 0, a, 32'h0);
    rd_check("R10", 3, A_CMPLO, 32'h0);
    check("R10", {60'h0, irq}, 64'h0);
    #1 check("R9 idle read", {32'h0, rdata}, 64'h0);
  endtask

  task automatic t_counter_write;
    wr(0, A_CLO, 32'h10);
    wr(0, A_CHI, 32'h1);
    rd_check("R2 lo", 0, A_CLO, 32'h10);
    rd_check("R2 hi", 0, A_CHI, 32'h1);
    wr(0, A_CTRL, 32'h1);         // E0
    wr(0, A_CLO, 32'hDEAD);       // E1, blocked
    wr(0, A_CTRL, 32'h0);         // E2, last tick
    rd_check("R2 blocked", 0, A_CLO, 32'h12);
    rd_check("R2 hi kept", 0, A_CHI, 32'h1);
  endtask

  task automatic t_prescale;
    wr(0, A_CLO, 0);
    wr(0, A_CHI, 0);
    wr(0, A_CTRL, 32'h0301);      // P=3, run at E0
    idle(10);
    wr(0, A_CTRL, 32'h0);         // stop at E11: ticks at E4, E8
    rd_check("R1 prescale", 0, A_CLO, 32'd2);
    idle(5);
    rd_check("R1 hold", 0, A_CLO, 32'd2);
  endtask

  task automatic t_carry;
    wr(0, A_CLO, 32'hFFFF_FFFF);
    wr(0, A_CHI, 0);
    wr(0, A_CTRL, 32'h1);
    wr(0, A_CTRL, 32'h0);
    rd_check("R1 carry lo", 0, A_CLO, 32'h0);
    rd_check("R1 carry hi", 0, A_CHI, 32'h1);
  endtask

  task automatic t_compare_irq;
    logic [31:0] d;
    wr(1, A_CTRL, 0);
    wr(1, A_CLO, 0);
    wr(1, A_CHI, 0);
    wr(1, A_CMPLO, 5);
    wr(1, A_CMPHI, 0);
    wr(1, A_CTRL, 32'h7);         // run, cmp, ie at E0
    idle(6);
    #1 check("R4 before event", {60'h0, irq}, 64'h0);
    idle(1);
    #1 check("R4 R5 event irq", {60'h0, irq}, 64'h2);
    rd_check("R11 other status", 0, A_STS, 0);
    wr(1, A_CTRL, 32'h1);         // cmp off, ie off
    check("R5 gated", {60'h0, irq}, 64'h0);
    rd_check("R5 status kept", 1, A_STS, 1);
    wr(1, A_STS, 0);
    rd_check("R6 zero write", 1, A_STS, 1);
    wr(1, A_CTRL, 32'h5);
    check("R5 ie on", {60'h0, irq}, 64'h2);
    wr(1, A_STS, 1);
    check("R6 cleared irq", {60'h0, irq}, 64'h0);
    rd_check("R6 cleared", 1, A_STS, 0);
    wr(1, A_CTRL, 32'h3);         // compare active again
    wr(1, A_STS, 1);              // event wins
    rd_check("R6 event wins", 1, A_STS, 1);
    rd(1, A_CLO, d);
    wr(1, A_CTRL, 0);
    wr(1, A_STS, 1);
    rd_check("R6 final clear", 1, A_STS, 0);
  endtask

  task automatic t_ctrl_merge;
    wr(2, A_CTRL, 32'h0000_0F0B);
    rd_check("R3 own bank", 2, A_CTRL, 32'h0F0B);
    rd_check("R3 shared only", 0, A_CTRL, 32'h0F01);
    rd_check("R11 bank1", 1, A_CTRL, 32'h0F01);
    wr(2, A_CTRL, 0);
    rd_check("R3 cleared", 2, A_CTRL, 32'h0);
  endtask

  task automatic t_halves;
    wr(2, A_CMPHI, 32'hABCD);
    wr(2, A_CMPLO, 32'h1234);
    rd_check("R8 hi", 2, A_CMPHI, 32'hABCD);
    rd_check("R8 lo", 2, A_CMPLO, 32'h1234);
    wr(2, A_CMPLO, 32'h5678);
    rd_check("R8 hi kept", 2, A_CMPHI, 32'hABCD);
    rd_check("R8 lo new", 2, A_CMPLO, 32'h5678);
    rd_check("R11 bank3 cmp", 3, A_CMPLO, 32'h0);
    wr(2, A_STEP, 32'h77);
    rd_check("R8 step", 2, A_STEP, 32'h77);
    rd_check("R11 bank0 step", 0, A_STEP, 32'h0);
    rd_check("R9 unmapped", 2, A_NONE, 32'h0);
  endtask

  task automatic t_overshoot;
    logic [63:0] exp;
    wr(0, A_CTRL, 32'h000A);      // bank0 cmp+auto, run off
    wr(0, A_CLO, 100);
    wr(0, A_CHI, 0);
    wr(0, A_CMPLO, 10);
    wr(0, A_CMPHI, 0);
    wr(3, A_CMPLO, 10);
    wr(3, A_CMPHI, 0);
    wr(3, A_STEP, 25);
    wr(3, A_CTRL, 32'hFF0B);      // P=255 keeps count at 100
    idle(20);
    wr(3, A_CTRL, 0);
    exp = 10 + ((100 - 10) / 25 + 1) * 25;
    rd_check("R7 overshoot", 3, A_CMPLO, exp[31:0]);
    rd_check("R7 count held", 3, A_CLO, 32'd100);
    rd_check("R7 zero step", 0, A_CMPLO, 32'd10);
    rd_check("R4 zero step status", 0, A_STS, 1);
    rd_check("R4 overshoot status", 3, A_STS, 1);
  endtask

  task automatic t_periodic;
    wr(1, A_CTRL, 0);
    wr(1, A_STS, 1);
    wr(1, A_CLO, 0);
    wr(1, A_CHI, 0);
    wr(1, A_CMPLO, 4);
    wr(1, A_STEP, 4);
    wr(1, A_CTRL, 32'h000F);      // run at E0
    idle(20);
    wr(1, A_CTRL, 0);             // stop at E21
    // count 21; events at E5,E9,..,E21 leave compare at 24
    rd_check("R1 periodic count", 1, A_CLO, 32'd21);
    rd_check("R7 periodic cmp", 1, A_CMPLO, 32'd24);
    rd_check("R4 periodic status", 1, A_STS, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counter_write();
    t_prescale();
    t_carry();
    t_compare_irq();
    t_ctrl_merge();
    t_halves();
    t_overshoot();
    t_periodic();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule